// File: doc/BRIEF.md
# GPIO Controller with Pin-Change Interrupts

This block manages 64 general-purpose pins, arranged as two banks of 32. For each pin, software sets a direction bit, a bit that hands the pin to an alternate function, and an output data bit. Software can also read the pin level back after it has passed through a synchronizer. All of these registers sit on a plain 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Pins 0 to 15 can also raise interrupts. Three per-pin trigger bits (edge, high, low) choose the detection mode:

| (edge, high, low) | Detection |
|---|---|
| (0,0,0) | off |
| (0,0,1) | level-low |
| (0,1,0) | level-high |
| (1,1,0) | rising edge |
| (1,0,1) | falling edge |
| (1,1,1) | both edges |

Detection results collect in a status register. An enable register masks them into one combined interrupt line. A pending edge is removed by writing 1 and then 0 to the pin's bit in a clear register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every direction, select, output, trigger, enable and status bit is 0. `pad_oe` is all zero and `irq` is 0.
- R2: Pins 0..31 use the registers at byte offsets 0x000 (input), 0x004 (output), 0x008 (direction) and 0x014 (select). Pins 32..63 use 0x05C, 0x060, 0x064 and 0x068. In both cases the bit index is the pin number modulo 32.
- R3: `pad_oe` is high only when the direction bit is 1 and the select bit is 0. `alt_sel` mirrors the select bit. `pad_out` carries the output register, and output bits of input pins keep their written value on readback.
- R4: A pad level appears in the input register after two clock edges, and not after one.
- R5: The trigger registers sit at 0x020 (edge), 0x024 (high) and 0x028 (low), with bit i for pin i. In level mode, (0,0,1) or (0,1,0), the status bit follows the synchronized condition.
- R6: The edge modes (1,1,0) rising, (1,0,1) falling and (1,1,1) both set a status bit that stays set until it is cleared.
- R7: Trigger (0,0,0) never sets status.
- R8: In the clear register (0xFE8), writing 1 over a stored 0 removes a pending edge. Writing 1 over a stored 1 does nothing, so the bit must be written back to 0 first. In level mode with the condition still true, status stays set after a clear.
- R9: If a clear strikes in the same cycle as a new edge event on the same pin, the event wins and status stays set.
- R10: `irq` is the OR over pins of status (0xFE0) AND enable (0xFE4). Status reads the raw detection regardless of enable.
- R11: Only bits 15:0 of the trigger, status, enable and clear registers exist. Higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 64 | Pad levels |
| pad_out | output | 64 | Output data to pads |
| pad_oe | output | 64 | Pad output enable |
| alt_sel | output | 64 | Pin handed to alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
A clear write and a fresh edge event on the same pin can land on the same clock edge. The bench provokes this by raising the pad and then placing the clear write on the bus exactly two edges later, when the synchronized edge is being detected. It then judges that the status bit read afterwards is still 1. The table-driven part walks every trigger encoding over both pad transitions, with a clear between them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int BANK_W    = 32;
   localparam int ADDR_W    = 12;
   localparam int MAX_BANKS = 2;

   // per-bank register offsets, indexed by bank number
   localparam logic [ADDR_W-1:0] OFS_IN  [MAX_BANKS] = '{12'h000, 12'h05C};
   localparam logic [ADDR_W-1:0] OFS_OUT [MAX_BANKS] = '{12'h004, 12'h060};
   localparam logic [ADDR_W-1:0] OFS_DIR [MAX_BANKS] = '{12'h008, 12'h064};
   localparam logic [ADDR_W-1:0] OFS_SEL [MAX_BANKS] = '{12'h014, 12'h068};

   localparam logic [ADDR_W-1:0] OFS_TRG_EDGE = 12'h020;
   localparam logic [ADDR_W-1:0] OFS_TRG_HIGH = 12'h024;
   localparam logic [ADDR_W-1:0] OFS_TRG_LOW  = 12'h028;
   localparam logic [ADDR_W-1:0] OFS_STAT     = 12'hFE0;
   localparam logic [ADDR_W-1:0] OFS_ENA      = 12'hFE4;
   localparam logic [ADDR_W-1:0] OFS_CLR      = 12'hFE8;

   typedef struct packed {
      logic edge_m;
      logic high_m;
      logic low_m;
   } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
   parameter int          W     = 32,
   parameter int          AW    = 12,
   parameter logic [AW-1:0] A_IN  = '0,
   parameter logic [AW-1:0] A_OUT = '0,
   parameter logic [AW-1:0] A_DIR = '0,
   parameter logic [AW-1:0] A_SEL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  pins_sync,
   output logic [W-1:0]  out_q,
   output logic [W-1:0]  dir_q,
   output logic [W-1:0]  sel_q,
   output logic          rd_hit,
   output logic [W-1:0]  rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         sel_q <= '0;
      end else if (we) begin
         if (addr == A_OUT) out_q <= wdata;
         if (addr == A_DIR) dir_q <= wdata;
         if (addr == A_SEL) sel_q <= wdata;
      end
   end

   always_comb begin
      rd_hit  = 1'b1;
      rd_data = '0;
      if (addr == A_IN)       rd_data = pins_sync;
      else if (addr == A_OUT) rd_data = out_q;
      else if (addr == A_DIR) rd_data = dir_q;
      else if (addr == A_SEL) rd_data = sel_q;
      else                    rd_hit  = 1'b0;
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_sync,
   input  logic [N-1:0] cfg_edge,
   input  logic [N-1:0] cfg_high,
   input  logic [N-1:0] cfg_low,
   input  logic [N-1:0] clr_pulse,
   output logic [N-1:0] status_q,
   output logic [N-1:0] evt
);
   logic [N-1:0] prev_q;
   logic [N-1:0] st_nxt;

   for (genvar i = 0; i < N; i++) begin : g_pin
      trig_cfg_t cfg;
      logic      rise, fall, lvl;
      assign cfg  = '{edge_m: cfg_edge[i], high_m: cfg_high[i], low_m: cfg_low[i]};
      assign rise = pin_sync[i] & ~prev_q[i];
      assign fall = ~pin_sync[i] & prev_q[i];
      assign lvl  = (cfg.high_m & pin_sync[i]) | (cfg.low_m & ~pin_sync[i]);
      assign evt[i] = cfg.edge_m & ((cfg.high_m & rise) | (cfg.low_m & fall));
      // edge: sticky, a new event beats a clear; level: follow condition
      assign st_nxt[i] = cfg.edge_m ? (evt[i] | (status_q[i] & ~clr_pulse[i])) : lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         status_q <= '0;
      end else begin
         prev_q   <= pin_sync;
         status_q <= st_nxt;
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int IRQ_PINS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] alt_sel,
   output logic                irq
);
   localparam int NUM_BANKS = NUM_PINS / BANK_W;

   if (NUM_PINS % BANK_W != 0 || NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_pins
      $error("gpio_irq_ctrl: NUM_PINS must be 32 or 64");
   end
   if (IRQ_PINS < 1 || IRQ_PINS > BANK_W) begin : g_bad_irq
      $error("gpio_irq_ctrl: IRQ_PINS must be 1..32");
   end

   logic [NUM_PINS-1:0]  pin_sync;
   logic [NUM_PINS-1:0]  out_all, dir_all, sel_all;
   logic [NUM_BANKS-1:0] rd_hit;
   logic [31:0]          rd_bank [NUM_BANKS];

   logic [IRQ_PINS-1:0] edge_q, high_q, low_q, en_q, clr_q;
   logic [IRQ_PINS-1:0] clr_pulse, status_q, evt;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_pin_bank #(
         .W(BANK_W), .AW(ADDR_W),
         .A_IN(OFS_IN[b]), .A_OUT(OFS_OUT[b]), .A_DIR(OFS_DIR[b]), .A_SEL(OFS_SEL[b])
      ) bank_i (
         .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
         .pins_sync(pin_sync[b*BANK_W +: BANK_W]),
         .out_q(out_all[b*BANK_W +: BANK_W]),
         .dir_q(dir_all[b*BANK_W +: BANK_W]),
         .sel_q(sel_all[b*BANK_W +: BANK_W]),
         .rd_hit(rd_hit[b]), .rd_data(rd_bank[b])
      );
   end

   // interrupt configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         high_q <= '0;
         low_q  <= '0;
         en_q   <= '0;
         clr_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == OFS_TRG_EDGE) edge_q <= bus_wdata[IRQ_PINS-1:0];
         if (bus_addr == OFS_TRG_HIGH) high_q <= bus_wdata[IRQ_PINS-1:0];
         if (bus_addr == OFS_TRG_LOW)  low_q  <= bus_wdata[IRQ_PINS-1:0];
         if (bus_addr == OFS_ENA)      en_q   <= bus_wdata[IRQ_PINS-1:0];
         if (bus_addr == OFS_CLR)      clr_q  <= bus_wdata[IRQ_PINS-1:0];
      end
   end

   // a clear acts only where a stored 0 is overwritten with 1
   assign clr_pulse = (bus_we && bus_addr == OFS_CLR) ?
                      (bus_wdata[IRQ_PINS-1:0] & ~clr_q) : '0;

   gpio_irq_unit #(.N(IRQ_PINS)) irq_i (
      .clk(clk), .rst_n(rst_n),
      .pin_sync(pin_sync[IRQ_PINS-1:0]),
      .cfg_edge(edge_q), .cfg_high(high_q), .cfg_low(low_q),
      .clr_pulse(clr_pulse), .status_q(status_q), .evt(evt)
   );

   assign irq     = |(status_q & en_q);
   assign pad_out = out_all;
   assign pad_oe  = dir_all & ~sel_all;
   assign alt_sel = sel_all;

   function automatic logic [31:0] widen(input logic [IRQ_PINS-1:0] v);
      widen = '0;
      widen[IRQ_PINS-1:0] = v;
   endfunction

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_hit[b]) bus_rdata = rd_bank[b];
      end
      case (bus_addr)
         OFS_TRG_EDGE: bus_rdata = widen(edge_q);
         OFS_TRG_HIGH: bus_rdata = widen(high_q);
         OFS_TRG_LOW:  bus_rdata = widen(low_q);
         OFS_STAT:     bus_rdata = widen(status_q);
         OFS_ENA:      bus_rdata = widen(en_q);
         OFS_CLR:      bus_rdata = widen(clr_q);
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int IRQ_PINS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] alt_sel,
   input logic                irq,
   input logic [IRQ_PINS-1:0] status_q,
   input logic [IRQ_PINS-1:0] en_q,
   input logic [IRQ_PINS-1:0] edge_q,
   input logic [IRQ_PINS-1:0] high_q,
   input logic [IRQ_PINS-1:0] low_q,
   input logic [IRQ_PINS-1:0] clr_pulse,
   input logic [IRQ_PINS-1:0] evt
);
   logic cfg_wr;
   assign cfg_wr = bus_we && (bus_addr == OFS_TRG_EDGE || bus_addr == OFS_TRG_HIGH ||
                              bus_addr == OFS_TRG_LOW);

   // R3
   oe_alt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & alt_sel) == '0);

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);

   for (genvar i = 0; i < IRQ_PINS; i++) begin : g_pin
      // R6
      edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[i] && status_q[i] && !clr_pulse[i] && !cfg_wr) |=> status_q[i]);
      // R8
      clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[i] && clr_pulse[i] && !evt[i] && !cfg_wr) |=> !status_q[i]);
      // R9
      event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && !cfg_wr) |=> status_q[i]);
      // R7
      quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_q[i] && !high_q[i] && !low_q[i] && !cfg_wr) |=> !status_q[i]);
   end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .IRQ_PINS(IRQ_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq),
   .status_q(status_q), .en_q(en_q), .edge_q(edge_q), .high_q(high_q), .low_q(low_q),
   .clr_pulse(clr_pulse), .evt(evt)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   localparam logic [11:0] A_IN0  = 12'h000, A_OUT0 = 12'h004, A_DIR0 = 12'h008;
   localparam logic [11:0] A_IN1  = 12'h05C, A_OUT1 = 12'h060, A_DIR1 = 12'h064, A_SEL1 = 12'h068;
   localparam logic [11:0] A_EDGE = 12'h020, A_HIGH = 12'h024, A_LOW = 12'h028;
   localparam logic [11:0] A_STAT = 12'hFE0, A_ENA = 12'hFE4, A_CLR = 12'hFE8;

   // {edge, high, low, pad_before, pad_after, expected_status} on pin 3
   localparam logic [5:0] VEC [12] = '{
      6'b001_10_1, 6'b001_01_0,
      6'b010_01_1, 6'b010_10_0,
      6'b110_01_1, 6'b110_10_0,
      6'b101_10_1, 6'b101_01_0,
      6'b111_01_1, 6'b111_10_1,
      6'b000_01_0, 6'b000_10_0
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pad_in = '0;
   logic [63:0] pad_out, pad_oe, alt_sel;
   logic        irq;

   int total = 0;
   int bad   = 0;
   logic [31:0] rv;
   logic [5:0]  v;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(A_DIR0, rv); check("R1 dir", rv, 0);
      rd(A_STAT, rv); check("R1 status", rv, 0);
      check("R1 pad_oe", pad_oe, 0);
      check("R1 irq", irq, 0);

      // table walk over trigger encodings (R5 R6 R7 R8)
      for (int k = 0; k < 12; k++) begin
         v = VEC[k];
         @(negedge clk) pad_in[3] = v[2];
         idle(4);
         wr(A_EDGE, 32'(v[5]) << 3);
         wr(A_HIGH, 32'(v[4]) << 3);
         wr(A_LOW,  32'(v[3]) << 3);
         idle(2);
         wr(A_CLR, 32'h8);
         wr(A_CLR, 32'h0);
         @(negedge clk) pad_in[3] = v[1];
         idle(5);
         rd(A_STAT, rv);
         check($sformatf("R5/R6/R7 vec%0d status", k), rv[3], v[0]);
      end
      wr(A_EDGE, 0); wr(A_HIGH, 0); wr(A_LOW, 0);

      // R2 / R3 banking and pad enables
      wr(A_DIR1, 32'h5);
      wr(A_SEL1, 32'h4);
      check("R2 R3 oe bank1", pad_oe[34:32], 3'b001);
      check("R3 alt_sel", alt_sel[34], 1);
      wr(A_OUT1, 32'hA5);
      check("R2 pad_out bank1", pad_out[39:32], 8'hA5);
      rd(A_OUT1, rv); check("R3 out readback", rv, 32'hA5);
      wr(A_DIR0, 32'h4);
      wr(A_OUT0, 32'hF0F0_0004);
      check("R3 pad_out bank0", pad_out[31:0], 64'hF0F0_0004);
      check("R3 oe bank0", pad_oe[31:0], 64'h4);

      // R4 synchronizer latency
      @(negedge clk) begin pad_in[40] = 1'b1; bus_addr = A_IN1; end
      @(negedge clk) check("R4 after one edge", bus_rdata[8], 0);
      @(negedge clk) check("R4 after two edges", bus_rdata[8], 1);

      // R11 implemented width
      wr(A_EDGE, 32'hFFFF_FFFF);
      rd(A_EDGE, rv); check("R11 trigger width", rv, 32'h0000_FFFF);
      wr(A_EDGE, 0);

      // R6 / R8 on pin 5, rising
      wr(A_EDGE, 32'h20); wr(A_HIGH, 32'h20);
      @(negedge clk) pad_in[5] = 1'b1;
      idle(4);
      rd(A_STAT, rv); check("R6 rising sets", rv[5], 1);
      @(negedge clk) pad_in[5] = 1'b0;
      idle(4);
      rd(A_STAT, rv); check("R6 sticky", rv[5], 1);
      wr(A_CLR, 32'h20);
      rd(A_STAT, rv); check("R8 clear", rv[5], 0);
      @(negedge clk) pad_in[5] = 1'b1;
      idle(4);
      wr(A_CLR, 32'h20);
      rd(A_STAT, rv); check("R8 repeated one ignored", rv[5], 1);
      wr(A_CLR, 0);
      wr(A_CLR, 32'h20);
      rd(A_STAT, rv); check("R8 rearmed clear", rv[5], 0);
      wr(A_CLR, 0);

      // R10 enable gating
      @(negedge clk) pad_in[5] = 1'b0;
      idle(3);
      @(negedge clk) pad_in[5] = 1'b1;
      idle(4);
      check("R10 irq masked", irq, 0);
      wr(A_ENA, 32'h20);
      check("R10 irq enabled", irq, 1);
      wr(A_ENA, 0);
      check("R10 irq disabled", irq, 0);
      rd(A_STAT, rv); check("R10 raw status", rv[5], 1);

      // R9 clear and new event in the same cycle
      @(negedge clk) pad_in[5] = 1'b0;
      idle(3);
      @(negedge clk) pad_in[5] = 1'b1;
      @(negedge clk);
      @(negedge clk) begin bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h20; end
      @(negedge clk) bus_we = 1'b0;
      rd(A_STAT, rv); check("R9 event wins", rv[5], 1);
      wr(A_CLR, 0);

      // R8 level re-assert on pin 6
      wr(A_HIGH, 32'h60);
      @(negedge clk) pad_in[6] = 1'b1;
      idle(4);
      wr(A_CLR, 32'h40);
      rd(A_STAT, rv); check("R8 level reasserts", rv[6], 1);
      wr(A_CLR, 0);
      @(negedge clk) pad_in[6] = 1'b0;
      idle(4);
      rd(A_STAT, rv); check("R5 level drops", rv[6], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule